// File: doc/BRIEF.md
# Prioritised Interrupt Pending Detector

This block watches seven active-low interrupt request lines on behalf of a processor core. It passes each line through a two-stage synchroniser and picks out the highest asserted level. It then decides whether that level should interrupt the core. Levels 1 to 6 are maskable: they interrupt only when they rise above the core's three-bit priority mask. Level 7 cannot be masked. It is taken on an edge rather than on a held level, and two rules decide when a request that is still held at 7 may be taken again.

Once a request qualifies, the block raises a pending flag and latches the level that caused it. Both stay fixed until exception processing pulses the acknowledge strobe. After the acknowledge, the block looks at the inputs again on the following clock. Fetching the vector and running the acknowledge bus cycle are left to the surrounding logic.

Top module: `irq_pend_det`

## Requirements
- R1: Every request line goes through two flip-flops before it is used. A change on the request lines reaches the pending outputs at the third rising clock edge after it is applied, and is not visible after the second.
- R2: Input bit k of the request bus (k = 0..6) is level k+1, and a 0 on that bit means the level is asserted. The encoded level is the highest asserted one. If no line is asserted the level is 0 and nothing becomes pending.
- R3: An encoded level from 1 to 6 becomes pending only when it is strictly greater than the mask. A level equal to or below the mask does not become pending.
- R4: When the encoded level changes to 7, level 7 becomes pending for every mask value, including 7.
- R5: After a level-7 request has been latched and acknowledged, the same request held continuously at 7 does not become pending again.
- R6: If the synchronised level leaves 7 for at least one clock and then returns to 7, the request is recognised again.
- R7: If the mask changes from 7 to a lower value while the request is held at 7, a second level-7 interrupt becomes pending. The pending output rises at the second rising edge after the mask change.
- R8: The pending flag and the latched level stay unchanged, even if the requests go away, until an acknowledge is sampled while the flag is set. That acknowledge clears both to 0 at the same edge. An acknowledge sampled while nothing is pending has no effect.
- R9: The inputs are evaluated again on the clock after an acknowledge. A request that still qualifies becomes pending one edge later. A request that qualifies in the same cycle as an acknowledge is not latched in that cycle and is latched on the following edge.
- R10: While reset is asserted and immediately after it, the pending flag is 0 and the latched level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n_i | input | 7 | Active-low request lines; bit k is level k+1 |
| mask_i | input | 3 | Core priority mask, 0 to 7 |
| ack_i | input | 1 | Acknowledge strobe from exception processing |
| pend_o | output | 1 | An interrupt is pending |
| pend_lvl_o | output | 3 | Level of the pending interrupt, 0 when none is pending |

## Verification
The acknowledge and the recognition of a new request can fall in the same cycle. This matters most for a fresh level-7 edge that reaches the synchronised level exactly in the cycle when an acknowledge clears a pending level-3 request. The bench creates this overlap by asserting line 7 two cycles before it strobes the acknowledge. It passes only if the flag first drops to 0 and then rises with level 7 on the next edge. This shows that the acknowledge takes priority and that the level-7 edge is kept for the next cycle rather than lost. The bench also sweeps every request pattern against every mask value, checking the latency, the priority encoding, the masking, the acknowledge and the level-7 re-arm behaviour. Directed cases cover the one-clock removal and the mask drop.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  localparam int unsigned IRQ_LVLS    = 7;
  localparam int unsigned IRQ_LVL_W   = $clog2(IRQ_LVLS + 1);
  localparam int unsigned IRQ_SYNC_ST = 2;
endpackage

// File: rtl/irq_pend_sync.sv
module irq_pend_sync #(
  parameter int unsigned WIDTH  = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_n,
  output logic [WIDTH-1:0] q_n
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stg_d;
    if (s == 0) begin : g_first
      assign stg_d = d_n;
    end else begin : g_next
      assign stg_d = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '1;
      else        stg_q[s] <= stg_d;
    end
  end

  assign q_n = stg_q[STAGES-1];
endmodule

// File: rtl/irq_pend_enc.sv
module irq_pend_enc #(
  parameter int unsigned LVLS  = 7,
  parameter int unsigned LVL_W = $clog2(LVLS + 1)
) (
  input  logic [LVLS-1:0]  req_n,
  output logic [LVL_W-1:0] lvl
);
  always_comb begin
    lvl = '0;
    for (int k = 0; k < LVLS; k++) begin
      if (!req_n[k]) lvl = LVL_W'(k + 1);
    end
  end
endmodule

// File: rtl/irq_pend_ctl.sv
module irq_pend_ctl #(
  parameter int unsigned LVLS  = 7,
  parameter int unsigned LVL_W = $clog2(LVLS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [LVL_W-1:0] mask_i,
  input  logic             ack_i,
  output logic             pend_o,
  output logic [LVL_W-1:0] pend_lvl_o
);
  localparam logic [LVL_W-1:0] TopLvl = LVL_W'(LVLS);

  logic             pend_q, pend_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             lvl_en;
  logic             armed_q, armed_d;
  logic [LVL_W-1:0] mprev_q;

  logic is_top, mask_drop, top_hit, low_hit, take;

  always_comb begin
    is_top    = (lvl_i == TopLvl);
    mask_drop = (mprev_q == TopLvl) && (mask_i != TopLvl);
    top_hit   = is_top && armed_q;
    low_hit   = !is_top && (lvl_i != '0) && (lvl_i > mask_i);
    take      = !pend_q && (top_hit || low_hit);

    pend_d = pend_q;
    lvl_d  = lvl_q;
    lvl_en = 1'b0;
    if (pend_q && ack_i) begin
      pend_d = 1'b0;
      lvl_d  = '0;
      lvl_en = 1'b1;
    end else if (take) begin
      pend_d = 1'b1;
      lvl_d  = lvl_i;
      lvl_en = 1'b1;
    end

    armed_d = armed_q;
    if (take && is_top)            armed_d = 1'b0;
    else if (!is_top || mask_drop) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      armed_q <= 1'b1;
      mprev_q <= '0;
    end else begin
      pend_q  <= pend_d;
      armed_q <= armed_d;
      mprev_q <= mask_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl_q <= '0;
    else if (lvl_en) lvl_q <= lvl_d;
  end

  assign pend_o     = pend_q;
  assign pend_lvl_o = lvl_q;
endmodule

// File: rtl/irq_pend_det.sv
module irq_pend_det
  import irq_pend_pkg::*;
#(
  parameter int unsigned LVLS   = IRQ_LVLS,
  parameter int unsigned STAGES = IRQ_SYNC_ST,
  localparam int unsigned LVL_W = $clog2(LVLS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVLS-1:0]  irq_n_i,
  input  logic [LVL_W-1:0] mask_i,
  input  logic             ack_i,
  output logic             pend_o,
  output logic [LVL_W-1:0] pend_lvl_o
);
  logic [LVLS-1:0]  req_sync_n;
  logic [LVL_W-1:0] cur_lvl;

  irq_pend_sync #(.WIDTH(LVLS), .STAGES(STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_n   (irq_n_i),
    .q_n   (req_sync_n)
  );

  irq_pend_enc #(.LVLS(LVLS), .LVL_W(LVL_W)) enc_i (
    .req_n (req_sync_n),
    .lvl   (cur_lvl)
  );

  irq_pend_ctl #(.LVLS(LVLS), .LVL_W(LVL_W)) ctl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .lvl_i      (cur_lvl),
    .mask_i     (mask_i),
    .ack_i      (ack_i),
    .pend_o     (pend_o),
    .pend_lvl_o (pend_lvl_o)
  );
endmodule

// File: rtl/irq_pend_det_chk.sv
module irq_pend_det_chk #(
  parameter int unsigned LVLS  = 7,
  parameter int unsigned LVL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] mask_i,
  input logic             ack_i,
  input logic             pend_o,
  input logic [LVL_W-1:0] pend_lvl_o
);
  localparam logic [LVL_W-1:0] TopLvl = LVL_W'(LVLS);

  // R2
  lvl_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_o |-> (pend_lvl_o != '0));

  // R8
  idle_lvl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_o |-> (pend_lvl_o == '0));

  // R8
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && ack_i) |=> !pend_o);

  // R8
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && !ack_i) |=> (pend_o && $stable(pend_lvl_o)));

  // R3
  rise_qualifies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_o) |-> ((pend_lvl_o == TopLvl) || (pend_lvl_o > $past(mask_i))));
endmodule

bind irq_pend_det irq_pend_det_chk #(.LVLS(LVLS), .LVL_W(LVL_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .mask_i     (mask_i),
  .ack_i      (ack_i),
  .pend_o     (pend_o),
  .pend_lvl_o (pend_lvl_o)
);

// File: tb/irq_pend_det_tb_top.sv
module irq_pend_det_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] irq_n;
  logic [2:0] mask;
  logic       ack;
  logic       pend;
  logic [2:0] plvl;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  irq_pend_det dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_n_i    (irq_n),
    .mask_i     (mask),
    .ack_i      (ack),
    .pend_o     (pend),
    .pend_lvl_o (plvl)
  );

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int enc_of(input int p);
    int e = 0;
    for (int k = 0; k < 7; k++) if (p[k]) e = k + 1;
    return e;
  endfunction

  task automatic pulse_ack();
    ack = 1'b1;
    nclk(1);
    ack = 1'b0;
  endtask

  task automatic go_idle();
    irq_n = '1;
    nclk(4);
    if (pend) pulse_ack();
    nclk(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    irq_n = '1;
    mask  = 3'd0;
    ack   = 1'b0;
    nclk(3);
    check("R10 pend in reset", int'(pend), 0);
    check("R10 lvl in reset", int'(plvl), 0);
    rst_n = 1'b1;
    nclk(1);
    check("R10 pend after reset", int'(pend), 0);

    // sweep every pattern against every mask (R1 R2 R3 R4 R5 R8 R9)
    for (int m = 0; m < 8; m++) begin
      for (int p = 0; p < 128; p++) begin
        int e, ep, el;
        irq_n = '1;
        nclk(4);
        mask = 3'(m);
        nclk(2);
        check("R2 idle no pend", int'(pend), 0);
        irq_n = ~7'(p);
        nclk(2);
        check("R1 not visible after two edges", int'(pend), 0);
        nclk(1);
        e  = enc_of(p);
        ep = (e == 7 || (e != 0 && e > m)) ? 1 : 0;
        el = ep ? e : 0;
        check("R2 R3 R4 pend", int'(pend), ep);
        check("R2 R3 R4 level", int'(plvl), el);
        if (ep == 1) begin
          pulse_ack();
          check("R8 ack clears", int'(pend), 0);
          if (e == 7) begin
            nclk(4);
            check("R5 held level 7 no repeat", int'(pend), 0);
          end else begin
            nclk(1);
            check("R9 re-evaluate after ack", int'(pend), 1);
            check("R9 re-evaluate level", int'(plvl), e);
          end
        end
        irq_n = '1;
        nclk(4);
        if (pend) pulse_ack();
        pulse_ack();
        nclk(1);
        check("R8 idle ack ignored", int'(pend), 0);
      end
    end

    mask = 3'd0;
    go_idle();

    // R8: hold after request removed
    irq_n = ~7'b0000100;
    nclk(3);
    check("R8 level 3 pend", int'(plvl), 3);
    irq_n = '1;
    nclk(5);
    check("R8 held after removal", int'(pend), 1);
    check("R8 level held", int'(plvl), 3);
    pulse_ack();
    check("R8 cleared", int'(pend), 0);
    go_idle();

    // R7: mask drop from 7 with request held at 7
    mask = 3'd7;
    nclk(3);
    irq_n = ~7'b1000000;
    nclk(3);
    check("R4 level 7 with mask 7", int'(plvl), 7);
    pulse_ack();
    nclk(3);
    check("R5 no repeat before mask drop", int'(pend), 0);
    mask = 3'd3;
    nclk(2);
    check("R7 mask drop pend", int'(pend), 1);
    check("R7 mask drop level", int'(plvl), 7);
    pulse_ack();
    nclk(4);
    check("R7 no repeat without new drop", int'(pend), 0);
    go_idle();
    mask = 3'd0;
    nclk(3);

    // R6: one-clock removal re-arms
    irq_n = ~7'b1000000;
    nclk(3);
    check("R4 level 7 pend", int'(pend), 1);
    pulse_ack();
    nclk(3);
    check("R5 held no repeat", int'(pend), 0);
    irq_n[6] = 1'b1;
    nclk(1);
    irq_n[6] = 1'b0;
    nclk(3);
    check("R6 re-armed pend", int'(pend), 1);
    check("R6 re-armed level", int'(plvl), 7);
    go_idle();

    // R9: acknowledge and new level-7 edge in the same cycle
    irq_n = ~7'b0000100;
    nclk(3);
    check("R9 level 3 pend first", int'(plvl), 3);
    irq_n = ~7'b1000100;
    nclk(2);
    ack = 1'b1;
    nclk(1);
    ack = 1'b0;
    check("R9 ack wins same cycle", int'(pend), 0);
    nclk(1);
    check("R9 level 7 next edge", int'(pend), 1);
    check("R9 level 7 value", int'(plvl), 7);
    go_idle();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule